// File: doc/BRIEF.md
# Grid Scan and Brightness Duty Generator

This block drives the grid electrodes of a multi-digit dot-matrix fluorescent display. It runs from the oscillator clock and splits time into fixed digit slots of 1024 clocks. A frame is always 24 slots long. In each slot one grid is selected. That grid and the anode enable are held active for a programmable number of clocks from the start of the slot, and are then blanked for the rest of the slot.

Two settings control the scan. The brightness value is 10 bits wide and gives the lit time in clocks. It is limited to 960, so every slot keeps a dark gap of at least 64 clocks. The digit-count code is 4 bits wide and selects how many grids take part, from 9 up to 24. Slots past the last enabled grid stay dark, so the frame rate is the same for every digit count. Each setting is loaded through a value bus with a one-cycle load strobe. A loaded value only takes effect at the next slot boundary.

The outputs are a one-hot grid vector, the index of the current slot, and an anode enable strobe. A display controller uses the enable strobe to gate its segment outputs.

Top module: `gscan_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every grid output is low, the anode enable is low and the digit index is 0. Reset sets the brightness value to 0 and the digit-count code to 0.
- R2: Each slot lasts exactly 1024 clocks. The digit index counts up by one per slot from 0 to 23 and then wraps to 0, which gives a frame of 24576 clocks.
- R3: For a brightness value D from 1 to 960, clocks 0 to D-1 of a slot are lit and the remaining clocks are dark. A lit clock of an enabled slot has the anode enable high and only grid bit [digit index] high.
- R4: Any brightness value from 960 to 1023 gives exactly 960 lit clocks. The last 64 clocks of every slot are always dark.
- R5: Digit code 0 enables 24 grids. Code K from 1 to 15 enables grids 0 to 7+K, which is 8+K grids. In slots with an index at or above the enabled count, all grid outputs and the anode enable stay low, and the frame stays 24 slots long.
- R6: A value that is loaded during a slot does not change that slot. It governs every slot from the next slot boundary onward.
- R7: With a brightness value of 0, no grid output and no anode enable is ever high.
- R8: At most one grid output is high in any cycle. A grid output is high only while the anode enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_val | input | 10 | Brightness value, lit clocks per slot |
| duty_load | input | 1 | One-cycle strobe that captures duty_val |
| dig_code | input | 4 | Digit-count code |
| dig_load | input | 1 | One-cycle strobe that captures dig_code |
| grid | output | 24 | One-hot grid drive, bit n drives grid n+1 |
| digit_idx | output | 5 | Index of the current slot, 0 to 23 |
| disp_en | output | 1 | Anode enable for the current slot |

## Verification
The assertions assume that reset is held for at least one clock edge, so that the counters hold defined values before any check is enabled. They also assume that the load strobes are single-cycle pulses with valid data on the value buses; nothing beyond this is required of the inputs. The bench drives every load at clock 300 of a slot, well away from the slot boundary, so the capture edge and the boundary edge never fall in the same cycle. Every load value is an in-range 10-bit or 4-bit code, including the 959, 960 and 1023 edges of the brightness value and the 1 and 15 edges of the digit code.

// File: rtl/gscan_pkg.sv
// Package: shared helpers for the grid scan generator.
// Holds the setting decoders, so that the configuration stage and the
// checkers agree on how a raw code maps to a count.
package gscan_pkg;

    // Limit a raw brightness value to the largest lit time allowed.
    function automatic int unsigned clamp_on(input int unsigned raw,
                                             input int unsigned max_on);
        return (raw > max_on) ? max_on : raw;
    endfunction

    // Map a digit code to a grid count: 0 means every grid, else base+code.
    function automatic int unsigned code_to_count(input int unsigned code,
                                                  input int unsigned base,
                                                  input int unsigned full);
        return (code == 0) ? full : base + code;
    endfunction

endpackage

// File: rtl/gscan_timer.sv
// Module: gscan_timer
// Counts oscillator clocks within a slot and slots within a frame.
// Assumes: SLOT_CLKS is a power of two, so the clock counter wraps
// naturally; NUM_GRIDS slots make one frame.
module gscan_timer #(
    parameter int SLOT_CLKS = 1024,
    parameter int NUM_GRIDS = 24,
    localparam int CNT_W    = $clog2(SLOT_CLKS),
    localparam int IDX_W    = $clog2(NUM_GRIDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] clk_cnt,
    output logic [IDX_W-1:0] slot,
    output logic             slot_end
);

    localparam logic [CNT_W-1:0] LAST_CLK  = CNT_W'(SLOT_CLKS - 1);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_GRIDS - 1);

    // Flag the final clock of a slot.
    assign slot_end = (clk_cnt == LAST_CLK);

    // Advance the clock-in-slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        clk_cnt <= '0;
        else if (slot_end) clk_cnt <= '0;
        else               clk_cnt <= clk_cnt + 1'b1;
    end

    // Advance the slot index at each slot end, wrapping once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 slot <= '0;
        else if (slot_end) begin
            if (slot == LAST_SLOT)  slot <= '0;
            else                    slot <= slot + 1'b1;
        end
    end

    // R2: a new slot always starts at clock zero
    p_slot_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (clk_cnt == '0));

    // R2: the index holds through a slot
    p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> $stable(slot));

    // R2: the index climbs by one at a slot end, except at the frame end
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && slot != LAST_SLOT) |=> (slot == $past(slot) + 1'b1));

    // R2: the frame wraps after the last slot
    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && slot == LAST_SLOT) |=> (slot == '0));

    // R2: the index never leaves its range
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_SLOT);

endmodule

// File: rtl/gscan_cfg.sv
// Module: gscan_cfg
// Holds the brightness and digit-count settings. A staging copy captures
// each load strobe; the live copy is refreshed only at a slot end.
// Assumes: the load strobes are one-cycle pulses with valid data.
module gscan_cfg #(
    parameter int DUTY_W    = 10,
    parameter int CODE_W    = 4,
    parameter int MAX_ON    = 960,
    parameter int NUM_GRIDS = 24,
    parameter int BASE_CNT  = 8,
    localparam int NUM_W    = $clog2(NUM_GRIDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_val,
    input  logic              duty_load,
    input  logic [CODE_W-1:0] dig_code,
    input  logic              dig_load,
    input  logic              slot_end,
    output logic [DUTY_W-1:0] on_len,
    output logic [NUM_W-1:0]  grid_cnt
);

    import gscan_pkg::*;

    logic [DUTY_W-1:0] duty_stage;
    logic [CODE_W-1:0] code_stage;
    logic [DUTY_W-1:0] on_next;
    logic [NUM_W-1:0]  cnt_next;

    // Capture host values into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_stage <= '0;
            code_stage <= '0;
        end else begin
            if (duty_load) duty_stage <= duty_val;
            if (dig_load)  code_stage <= dig_code;
        end
    end

    // Decode the staged values into a lit length and a grid count.
    always_comb begin
        on_next  = DUTY_W'(clamp_on(int'(duty_stage), MAX_ON));
        cnt_next = NUM_W'(code_to_count(int'(code_stage), BASE_CNT, NUM_GRIDS));
    end

    // Refresh the live settings only at the slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_len   <= '0;
            grid_cnt <= NUM_W'(NUM_GRIDS);
        end else if (slot_end) begin
            on_len   <= on_next;
            grid_cnt <= cnt_next;
        end
    end

    // R4: the live lit length never exceeds the clamp
    p_on_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        on_len <= DUTY_W'(MAX_ON));

    // R5: the live grid count stays within base+1 .. all grids
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_cnt >= NUM_W'(BASE_CNT + 1)) && (grid_cnt <= NUM_W'(NUM_GRIDS)));

    // R6: live settings only move across a slot boundary
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end |=> ($stable(on_len) && $stable(grid_cnt)));

endmodule

// File: rtl/gscan_drive.sv
// Module: gscan_drive
// Forms the anode enable and the one-hot grid vector from the slot
// position and the live settings.
// Assumes: on_len is already limited, so the tail of each slot is dark.
module gscan_drive #(
    parameter int SLOT_CLKS = 1024,
    parameter int NUM_GRIDS = 24,
    parameter int DUTY_W    = 10,
    parameter int MAX_ON    = 960,
    localparam int CNT_W    = $clog2(SLOT_CLKS),
    localparam int IDX_W    = $clog2(NUM_GRIDS),
    localparam int NUM_W    = $clog2(NUM_GRIDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     clk_cnt,
    input  logic [IDX_W-1:0]     slot,
    input  logic [DUTY_W-1:0]    on_len,
    input  logic [NUM_W-1:0]     grid_cnt,
    output logic [NUM_GRIDS-1:0] grid,
    output logic                 disp_en
);

    logic in_window;
    logic slot_used;

    // Decide whether this clock of this slot is lit.
    always_comb begin
        in_window = (DUTY_W'(clk_cnt) < on_len);
        slot_used = (NUM_W'(slot) < grid_cnt);
        disp_en   = in_window && slot_used;
    end

    // One decoder per grid line.
    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_line
        assign grid[g] = disp_en && (slot == IDX_W'(g));
    end

    // R8: never more than one grid active
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid));

    // R8: an active grid implies the anode enable
    p_grid_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grid != '0) |-> disp_en);

    // R4: the slot tail past the clamp is always dark
    p_blank_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_cnt >= CNT_W'(MAX_ON)) |-> (grid == '0 && !disp_en));

    // R7: a zero lit length keeps every grid low
    p_dark_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (on_len == '0) |-> (grid == '0));

    // R5: slots beyond the enabled count stay dark
    p_unused_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_W'(slot) >= grid_cnt) |-> !disp_en);

endmodule

// File: rtl/gscan_top.sv
// Module: gscan_top
// Grid scan and brightness duty generator: fixed-length digit slots, a
// clamped lit window per slot, and a selectable number of active grids.
// Assumes: synchronous active-low reset held for at least one edge.
module gscan_top #(
    parameter int SLOT_CLKS = 1024,
    parameter int NUM_GRIDS = 24,
    parameter int MAX_ON    = 960,
    parameter int BASE_CNT  = 8,
    parameter int DUTY_W    = 10,
    parameter int CODE_W    = 4,
    localparam int CNT_W    = $clog2(SLOT_CLKS),
    localparam int IDX_W    = $clog2(NUM_GRIDS),
    localparam int NUM_W    = $clog2(NUM_GRIDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DUTY_W-1:0]    duty_val,
    input  logic                 duty_load,
    input  logic [CODE_W-1:0]    dig_code,
    input  logic                 dig_load,
    output logic [NUM_GRIDS-1:0] grid,
    output logic [IDX_W-1:0]     digit_idx,
    output logic                 disp_en
);

    logic [CNT_W-1:0]  clk_cnt;
    logic [IDX_W-1:0]  slot;
    logic              slot_end;
    logic [DUTY_W-1:0] on_len;
    logic [NUM_W-1:0]  grid_cnt;

    gscan_timer #(
        .SLOT_CLKS(SLOT_CLKS), .NUM_GRIDS(NUM_GRIDS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clk_cnt(clk_cnt), .slot(slot), .slot_end(slot_end)
    );

    gscan_cfg #(
        .DUTY_W(DUTY_W), .CODE_W(CODE_W), .MAX_ON(MAX_ON),
        .NUM_GRIDS(NUM_GRIDS), .BASE_CNT(BASE_CNT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .duty_val(duty_val), .duty_load(duty_load),
        .dig_code(dig_code), .dig_load(dig_load),
        .slot_end(slot_end),
        .on_len(on_len), .grid_cnt(grid_cnt)
    );

    gscan_drive #(
        .SLOT_CLKS(SLOT_CLKS), .NUM_GRIDS(NUM_GRIDS),
        .DUTY_W(DUTY_W), .MAX_ON(MAX_ON)
    ) u_drive (
        .clk(clk), .rst_n(rst_n),
        .clk_cnt(clk_cnt), .slot(slot),
        .on_len(on_len), .grid_cnt(grid_cnt),
        .grid(grid), .disp_en(disp_en)
    );

    // Publish the current slot as the digit index.
    assign digit_idx = slot;

endmodule

// File: tb/sim_gscan_top.sv
// Bench: directed scenarios against a cycle model built from the requirements.
module sim_gscan_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  duty_val = '0;
    logic        duty_load = 1'b0;
    logic [3:0]  dig_code = '0;
    logic        dig_load = 1'b0;
    logic [23:0] grid;
    logic [4:0]  digit_idx;
    logic        disp_en;

    int checks = 0;
    int fails  = 0;

    // Reference model state: position, staged and live settings.
    int m_cnt = 0, m_slot = 0;
    int m_duty_stage = 0, m_code_stage = 0;
    int m_duty = 0, m_code = 0;

    gscan_top u0 (
        .clk(clk), .rst_n(rst_n),
        .duty_val(duty_val), .duty_load(duty_load),
        .dig_code(dig_code), .dig_load(dig_load),
        .grid(grid), .digit_idx(digit_idx), .disp_en(disp_en)
    );

    always #4 clk = ~clk;

    // Model: 1024-clock slots, 24 per frame, settings applied at slot end.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_slot <= 0;
            m_duty_stage <= 0; m_code_stage <= 0;
            m_duty <= 0; m_code <= 0;
        end else begin
            if (duty_load) m_duty_stage <= int'(duty_val);
            if (dig_load)  m_code_stage <= int'(dig_code);
            if (m_cnt == 1023) begin
                m_cnt  <= 0;
                m_slot <= (m_slot == 23) ? 0 : m_slot + 1;
                m_duty <= m_duty_stage;
                m_code <= m_code_stage;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs with the model for n cycles, at the falling edge.
    task automatic observe(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            begin
                int on_clks  = (m_duty > 960) ? 960 : m_duty;
                int ngrid    = (m_code == 0) ? 24 : 8 + m_code;
                bit lit      = (m_cnt < on_clks) && (m_slot < ngrid);
                logic [23:0] eg = lit ? (24'd1 << m_slot) : 24'd0;
                check(disp_en == lit, req, "disp_en", int'(disp_en), int'(lit));
                check(grid == eg, req, "grid", int'(grid), int'(eg));
                check(int'(digit_idx) == m_slot, req, "digit_idx",
                      int'(digit_idx), m_slot);
            end
        end
    endtask

    // Load both settings at clock 300 of a slot, away from the boundary.
    task automatic load_cfg(input int duty, input int code);
        while (m_cnt != 300) @(negedge clk);
        duty_val = 10'(duty); duty_load = 1'b1;
        dig_code = 4'(code);  dig_load  = 1'b1;
        @(negedge clk);
        duty_load = 1'b0; dig_load = 1'b0;
    endtask

    // Run until the model is at clock 0 of slot 0.
    task automatic to_frame_start();
        while (!(m_cnt == 0 && m_slot == 0)) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(grid == '0 && !disp_en && digit_idx == '0, "R1", "in reset",
              int'(grid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grid == '0 && !disp_en && digit_idx == '0, "R1", "after reset",
              int'(grid), 0);
        observe(2048, "R7");
    endtask

    task automatic t_duty_normal();
        load_cfg(100, 0);
        observe(1024 - 301, "R6");
        to_frame_start();
        observe(24576, "R3");
    endtask

    task automatic t_clamp();
        load_cfg(1023, 0);
        observe(1024 * 3, "R4");
        load_cfg(960, 0);
        observe(1024 * 2, "R4");
        load_cfg(959, 0);
        observe(1024 * 2, "R3");
        load_cfg(1, 0);
        observe(1024 * 2, "R3");
    endtask

    task automatic t_digits();
        load_cfg(500, 1);
        to_frame_start();
        observe(24576, "R5");
        load_cfg(960, 15);
        to_frame_start();
        observe(24576, "R5");
        observe(1, "R2");
    endtask

    task automatic t_back_to_zero();
        load_cfg(0, 0);
        observe(1024 * 3, "R7");
        check(u0.grid == '0, "R8", "final grid", int'(grid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_duty_normal();
        t_clamp();
        t_digits();
        t_back_to_zero();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule